// File: doc/BRIEF.md
# Vector length setup unit

This unit keeps the three length registers of a vectorising processor: the active vector length (VL), its ceiling (MAXVL) and the sub-vector width (SUBVL). It is updated by a 16-bit setup header that may open a group of prefixed instructions, and by direct register writes from the control-register path. The header has two modes, picked by bit 15. In the loop-start mode the requested length comes from a 5-bit immediate or from a scalar register, and it is limited to MAXVL. In the fixed-size mode a 6-bit immediate loads MAXVL and VL together.

After every header commit the new VL can be mirrored into a scalar register through a register-file write port. Register 0 as the destination suppresses that write. When the length comes from a scalar register, the unit requests a register-file read and stalls, with busy asserted, until the read returns. A group flag follows start and end strobes. Closing a group leaves all three length registers untouched.

Header layout. Bit 15 selects the mode, with 0 for loop-start and 1 for fixed-size. Bits 12:8 name the destination register. In loop-start mode, bits 14:13 are the SUBVL code, bits 5:1 hold the immediate or the source register number, and bit 0 selects the register source (1) over the immediate (0). In fixed-size mode, bits 5:0 hold the 6-bit immediate. All other bits are ignored.

Top module: `vlen_setup_unit`

## Requirements
- R1: After reset VL is 0, MAXVL is MAXVL_RST (default 64), SUBVL is 0, and busy, rf_re, rf_we and in_group are all low.
- R2: An accepted loop-start header with bit 0 = 0 sets VL to the smaller of the 5-bit immediate and MAXVL, and sets SUBVL to bits 14:13. Both values are visible the cycle after the header strobe.
- R3: An accepted fixed-size header (bit 15 = 1) loads both MAXVL and VL with bits 5:0 the cycle after the strobe. SUBVL is left unchanged.
- R4: A loop-start header with bit 0 = 1 raises busy and rf_re, with rf_raddr equal to bits 5:1, from the cycle after the strobe. Both stay high until the edge that samples rf_rvalid. At that edge VL becomes the smaller of rf_rdata and MAXVL, and SUBVL takes the header's code.
- R5: In the cycle VL takes a header-committed value, rf_we is high for exactly one cycle, with rf_waddr equal to bits 12:8 and rf_wdata equal to the new VL, zero-extended.
- R6: When bits 12:8 are 0, a header commit leaves rf_we low.
- R7: A direct write with csr_we high updates VL (csr_sel 0), MAXVL (csr_sel 1) or SUBVL (csr_sel 2, low two bits) on the next cycle. This also applies inside a group and while busy. csr_sel 3 changes nothing.
- R8: When an accepted header strobe or a read completion falls in the same cycle as a direct write, the direct write is discarded.
- R9: grp_start sets in_group and grp_end clears it. start wins if both are high. Neither strobe changes VL, MAXVL or SUBVL.
- R10: A header strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header strobe |
| hdr | input | 16 | Setup header word |
| rf_re | output | 1 | Register-file read request |
| rf_raddr | output | 5 | Read register number |
| rf_rvalid | input | 1 | Read data valid |
| rf_rdata | input | XLEN | Read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Write register number |
| rf_wdata | output | XLEN | Write data (new VL) |
| csr_we | input | 1 | Direct length-register write |
| csr_sel | input | 2 | Target: 0 VL, 1 MAXVL, 2 SUBVL |
| csr_wdata | input | LEN_W | Direct write value |
| grp_start | input | 1 | Group open strobe |
| grp_end | input | 1 | Group close strobe |
| in_group | output | 1 | Inside a group |
| busy | output | 1 | Waiting on a register read |
| vl | output | LEN_W | Current VL |
| maxvl | output | LEN_W | Current MAXVL |
| subvl | output | 2 | Current SUBVL code |

## Verification
The loop-start immediate is tried both below and above MAXVL, which tells a clamp from a plain copy. The fixed-size header is checked for whether it moves MAXVL as well as VL. The register-sourced path is driven with a read value far above MAXVL and one below it, and a direct MAXVL write is placed in the wait window, so the clamp is shown to use the ceiling in force at completion. Collision cases, ignored headers during a stall, and group close with unchanged lengths separate the priority rules from ordinary updates.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int HDR_W = 16;
    localparam int RAW   = 5;

    typedef enum logic [1:0] {
        SEL_VL    = 2'd0,
        SEL_MAXVL = 2'd1,
        SEL_SUBVL = 2'd2
    } csr_sel_e;

    typedef struct packed {
        logic           fixed_mode;
        logic [1:0]     sub_code;
        logic [RAW-1:0] dest;
        logic [4:0]     len5;
        logic [5:0]     len6;
        logic           from_reg;
    } hdr_fields_t;

endpackage

// File: rtl/vls_hdr_decode.sv
module vls_hdr_decode
    import vls_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output hdr_fields_t      fields
);
    always_comb begin
        fields.fixed_mode = hdr[15];
        fields.sub_code   = hdr[14:13];
        fields.dest       = hdr[12:8];
        fields.len5       = hdr[5:1];
        fields.len6       = hdr[5:0];
        fields.from_reg   = hdr[0];
    end
endmodule

// File: rtl/vls_clamp.sv
module vls_clamp #(
    parameter int XLEN  = 32,
    parameter int LEN_W = 7
) (
    input  logic [XLEN-1:0]  req,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] result
);
    logic [XLEN-1:0] limit_ext;

    always_comb begin
        limit_ext = XLEN'(limit);
        if (req > limit_ext) begin
            result = limit;
        end else begin
            result = req[LEN_W-1:0];
        end
    end
endmodule

// File: rtl/vlen_setup_unit.sv
module vlen_setup_unit
    import vls_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int LEN_W     = 7,
    parameter int MAXVL_RST = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_valid,
    input  logic [15:0]          hdr,
    output logic                 rf_re,
    output logic [4:0]           rf_raddr,
    input  logic                 rf_rvalid,
    input  logic [XLEN-1:0]      rf_rdata,
    output logic                 rf_we,
    output logic [4:0]           rf_waddr,
    output logic [XLEN-1:0]      rf_wdata,
    input  logic                 csr_we,
    input  logic [1:0]           csr_sel,
    input  logic [LEN_W-1:0]     csr_wdata,
    input  logic                 grp_start,
    input  logic                 grp_end,
    output logic                 in_group,
    output logic                 busy,
    output logic [LEN_W-1:0]     vl,
    output logic [LEN_W-1:0]     maxvl,
    output logic [1:0]           subvl
);
    localparam int ZPAD = XLEN - LEN_W;

    typedef struct packed {
        logic [LEN_W-1:0] vl;
        logic [LEN_W-1:0] maxvl;
        logic [1:0]       subvl;
        logic             busy;
        logic [RAW-1:0]   raddr;
        logic [RAW-1:0]   pend_dest;
        logic [1:0]       pend_sub;
        logic             wr_en;
        logic [RAW-1:0]   wr_addr;
        logic [LEN_W-1:0] wr_val;
        logic             in_grp;
    } state_t;

    state_t      st_d, st_q;
    hdr_fields_t fld;
    logic [XLEN-1:0]  req_val;
    logic [LEN_W-1:0] clamped;
    logic             accept_hdr;
    logic             rd_done;
    logic             vl_commit;

    vls_hdr_decode u_dec (
        .hdr    (hdr),
        .fields (fld)
    );

    vls_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_clamp (
        .req    (req_val),
        .limit  (st_q.maxvl),
        .result (clamped)
    );

    always_comb begin
        accept_hdr = hdr_valid && !st_q.busy;
        rd_done    = st_q.busy && rf_rvalid;
        req_val    = st_q.busy ? rf_rdata : XLEN'(fld.len5);
        vl_commit  = 1'b0;

        st_d       = st_q;
        st_d.wr_en = 1'b0;

        if (accept_hdr) begin
            if (fld.fixed_mode) begin
                st_d.maxvl   = LEN_W'(fld.len6);
                st_d.vl      = LEN_W'(fld.len6);
                st_d.wr_en   = (fld.dest != '0);
                st_d.wr_addr = fld.dest;
                st_d.wr_val  = LEN_W'(fld.len6);
                vl_commit    = 1'b1;
            end else if (fld.from_reg) begin
                st_d.busy      = 1'b1;
                st_d.raddr     = fld.len5;
                st_d.pend_dest = fld.dest;
                st_d.pend_sub  = fld.sub_code;
            end else begin
                st_d.vl      = clamped;
                st_d.subvl   = fld.sub_code;
                st_d.wr_en   = (fld.dest != '0);
                st_d.wr_addr = fld.dest;
                st_d.wr_val  = clamped;
                vl_commit    = 1'b1;
            end
        end else if (rd_done) begin
            st_d.busy    = 1'b0;
            st_d.vl      = clamped;
            st_d.subvl   = st_q.pend_sub;
            st_d.wr_en   = (st_q.pend_dest != '0);
            st_d.wr_addr = st_q.pend_dest;
            st_d.wr_val  = clamped;
            vl_commit    = 1'b1;
        end else if (csr_we) begin
            case (csr_sel)
                SEL_VL:    st_d.vl    = csr_wdata;
                SEL_MAXVL: st_d.maxvl = csr_wdata;
                SEL_SUBVL: st_d.subvl = csr_wdata[1:0];
                default:   ;
            endcase
        end

        if (grp_start) begin
            st_d.in_grp = 1'b1;
        end else if (grp_end) begin
            st_d.in_grp = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vl        <= '0;
            st_q.maxvl     <= LEN_W'(MAXVL_RST);
            st_q.subvl     <= '0;
            st_q.busy      <= 1'b0;
            st_q.raddr     <= '0;
            st_q.pend_dest <= '0;
            st_q.pend_sub  <= '0;
            st_q.wr_en     <= 1'b0;
            st_q.wr_addr   <= '0;
            st_q.wr_val    <= '0;
            st_q.in_grp    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl       = st_q.vl;
    assign maxvl    = st_q.maxvl;
    assign subvl    = st_q.subvl;
    assign busy     = st_q.busy;
    assign rf_re    = st_q.busy;
    assign rf_raddr = st_q.raddr;
    assign rf_we    = st_q.wr_en;
    assign rf_waddr = st_q.wr_addr;
    assign rf_wdata = {{ZPAD{1'b0}}, st_q.wr_val};
    assign in_group = st_q.in_grp;

    // R5
    wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_wdata == XLEN'(vl)));

    // R2
    clamp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vl_commit |=> (vl <= maxvl));

    // R3
    fixed_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_hdr && fld.fixed_mode) |=> (vl == maxvl));

    // R4
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(hdr_valid));

    // R4
    raddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rf_rvalid) |=> (busy && $stable(rf_raddr)));

    // R6
    wb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != 5'd0));

    // R9
    grp_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_end && !grp_start && !hdr_valid && !csr_we && !busy) |=>
            ($stable(vl) && $stable(maxvl) && $stable(subvl)));
endmodule

// File: tb/vlen_setup_unit_bench.sv
module vlen_setup_unit_bench;
    localparam int XLEN  = 32;
    localparam int LEN_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             hdr_valid;
    logic [15:0]      hdr;
    logic             rf_re;
    logic [4:0]       rf_raddr;
    logic             rf_rvalid;
    logic [XLEN-1:0]  rf_rdata;
    logic             rf_we;
    logic [4:0]       rf_waddr;
    logic [XLEN-1:0]  rf_wdata;
    logic             csr_we;
    logic [1:0]       csr_sel;
    logic [LEN_W-1:0] csr_wdata;
    logic             grp_start;
    logic             grp_end;
    logic             in_group;
    logic             busy;
    logic [LEN_W-1:0] vl;
    logic [LEN_W-1:0] maxvl;
    logic [1:0]       subvl;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vlen_setup_unit u_vlen_setup_unit (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr(hdr),
        .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rvalid(rf_rvalid),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .grp_start(grp_start), .grp_end(grp_end),
        .in_group(in_group), .busy(busy), .vl(vl), .maxvl(maxvl),
        .subvl(subvl)
    );

    function automatic logic [15:0] loop_hdr(input logic [1:0] sc,
        input logic [4:0] dst, input logic [4:0] len, input logic use_reg);
        return {1'b0, sc, dst, 2'b00, len, use_reg};
    endfunction

    function automatic logic [15:0] fixed_hdr(input logic [4:0] dst,
        input logic [5:0] len);
        return {1'b1, 2'b00, dst, 2'b00, len};
    endfunction

    task automatic check(input bit ok, input string req, input longint act,
        input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        hdr_valid = 0; hdr = '0; rf_rvalid = 0; rf_rdata = '0;
        csr_we = 0; csr_sel = '0; csr_wdata = '0;
        grp_start = 0; grp_end = 0;
    endtask

    // inputs are set after a falling edge and sampled by the next rising edge
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic send_hdr(input logic [15:0] h);
        hdr_valid = 1; hdr = h;
        tick();
    endtask

    task automatic t_reset();
        check(vl == 0, "R1 vl", vl, 0);
        check(maxvl == 64, "R1 maxvl", maxvl, 64);
        check(subvl == 0, "R1 subvl", subvl, 0);
        check(!busy && !rf_re && !rf_we && !in_group, "R1 flags",
              {busy, rf_re, rf_we, in_group}, 0);
    endtask

    task automatic t_imm_below();
        send_hdr(loop_hdr(2'd2, 5'd3, 5'd20, 1'b0));
        check(vl == 20, "R2 imm vl", vl, 20);
        check(subvl == 2, "R2 subvl", subvl, 2);
        check(rf_we == 1 && rf_waddr == 3, "R5 we/addr", {rf_we, rf_waddr}, {1'b1, 5'd3});
        check(rf_wdata == 20, "R5 wdata", rf_wdata, 20);
        tick();
        check(rf_we == 0, "R5 one-cycle pulse", rf_we, 0);
    endtask

    task automatic t_fixed();
        send_hdr(fixed_hdr(5'd0, 6'd10));
        check(maxvl == 10 && vl == 10, "R3 maxvl/vl", {maxvl, vl}, {7'd10, 7'd10});
        check(subvl == 2, "R3 subvl kept", subvl, 2);
        check(rf_we == 0, "R6 dest zero", rf_we, 0);
    endtask

    task automatic t_imm_clamp();
        send_hdr(loop_hdr(2'd1, 5'd7, 5'd31, 1'b0));
        check(vl == 10, "R2 clamp vl", vl, 10);
        check(rf_we && rf_waddr == 7 && rf_wdata == 10, "R5 clamped wb", rf_wdata, 10);
    endtask

    task automatic t_reg_source();
        send_hdr(loop_hdr(2'd3, 5'd4, 5'd5, 1'b1));
        check(busy && rf_re && rf_raddr == 5, "R4 request", {busy, rf_re, rf_raddr}, {2'b11, 5'd5});
        tick();
        send_hdr(fixed_hdr(5'd1, 6'd3));
        check(maxvl == 10 && busy, "R10 hdr ignored", maxvl, 10);
        check(rf_we == 0, "R10 no wb", rf_we, 0);
        rf_rvalid = 1; rf_rdata = 1000;
        tick();
        check(vl == 10 && !busy && !rf_re, "R4 clamp reg", vl, 10);
        check(subvl == 3, "R4 subvl", subvl, 3);
        check(rf_we && rf_waddr == 4 && rf_wdata == 10, "R5 reg wb", rf_waddr, 4);
        send_hdr(loop_hdr(2'd0, 5'd0, 5'd9, 1'b1));
        rf_rvalid = 1; rf_rdata = 6;
        tick();
        check(vl == 6, "R4 below max", vl, 6);
        check(rf_we == 0, "R6 reg dest zero", rf_we, 0);
    endtask

    task automatic t_csr();
        csr_we = 1; csr_sel = 2'd1; csr_wdata = 40; tick();
        csr_we = 1; csr_sel = 2'd0; csr_wdata = 33; tick();
        csr_we = 1; csr_sel = 2'd2; csr_wdata = 7'd3; tick();
        check(maxvl == 40 && vl == 33 && subvl == 3, "R7 csr writes", vl, 33);
        csr_we = 1; csr_sel = 2'd3; csr_wdata = 1; tick();
        check(maxvl == 40 && vl == 33 && subvl == 3, "R7 sel 3 no effect", maxvl, 40);
    endtask

    task automatic t_collision();
        hdr_valid = 1; hdr = fixed_hdr(5'd0, 6'd12);
        csr_we = 1; csr_sel = 2'd0; csr_wdata = 50;
        tick();
        check(vl == 12 && maxvl == 12, "R8 header wins", vl, 12);
    endtask

    task automatic t_csr_while_busy();
        send_hdr(loop_hdr(2'd1, 5'd2, 5'd6, 1'b1));
        csr_we = 1; csr_sel = 2'd1; csr_wdata = 5; tick();
        check(maxvl == 5 && busy, "R7 csr while busy", maxvl, 5);
        rf_rvalid = 1; rf_rdata = 9;
        csr_we = 1; csr_sel = 2'd0; csr_wdata = 44;
        tick();
        check(vl == 5, "R8 completion beats csr", vl, 5);
    endtask

    task automatic t_group();
        grp_start = 1; tick();
        check(in_group == 1, "R9 start", in_group, 1);
        send_hdr(fixed_hdr(5'd0, 6'd20));
        csr_we = 1; csr_sel = 2'd0; csr_wdata = 17; tick();
        check(vl == 17 && maxvl == 20, "R7 csr in group", vl, 17);
        grp_end = 1; tick();
        check(in_group == 0, "R9 end", in_group, 0);
        check(vl == 17 && maxvl == 20 && subvl == 1, "R9 lengths kept", vl, 17);
        grp_start = 1; grp_end = 1; tick();
        check(in_group == 1, "R9 start wins", in_group, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_imm_below();
        t_fixed();
        t_imm_clamp();
        t_reg_source();
        t_csr();
        t_collision();
        t_csr_while_busy();
        t_group();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule